// File: doc/BRIEF.md
# Counter-Mode Keystream Sequencer

This block sits between a data stream and a 128-bit forward block-cipher engine and runs counter-mode encryption or decryption. Software loads a 128-bit counter block as four 32-bit words and selects counter operation through a 3-bit chaining-mode input. For each accepted data block, the sequencer hands the current counter block to the engine. It combines the returned keystream with the data by XOR and presents the result on a valid/ready output port.

The upper 96 bits of the counter block are a fixed nonce. Only the low 32-bit word counts, and it steps by one when each output block is taken. Encryption and decryption use the same path, because feeding ciphertext back in under the same counter values gives the plaintext. Software can read the counter block back word by word, so it can save the stream position and restore it later.

Top module: `ctr_keystream_seq`

## Requirements
- R1: `in_ready` is high only when no block is in progress and `chain_mode` equals 3'b010. With any other mode value, no input is accepted and `eng_start` stays low.
- R2: The counter block is made of four words. Word index 3 holds bits 127:96, index 2 holds 95:64, index 1 holds 63:32 and index 0 holds 31:0. `eng_block` carries this block unchanged.
- R3: Each output block equals the engine's keystream for the current counter block XORed with the accepted input block.
- R4: On every output handshake, word 0 increments by one before the next block uses it. Bits 127:32 do not change.
- R5: The increment is modulo 2^32. 32'hFFFFFFFF is followed by 32'h00000000, and the carry never reaches the nonce.
- R6: A word write is applied only while idle. A write made while a block is in flight leaves the counter block unchanged.
- R7: `eng_start` is a one-cycle pulse. At most one engine request is outstanding, and the next pulse comes only after the previous output handshake.
- R8: `out_valid` stays high and `out_data` stays stable until `out_ready` is seen.
- R9: `iv_rd_data` returns the counter-block word selected by `iv_rd_idx` one clock later, and it reflects increments.
- R10: After reset, `out_valid` and `eng_start` are low and the counter block is all zero.
- R11: Sending the ciphertext back through under the same starting counter reproduces the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_mode | input | 3 | Chaining-mode select; 3'b010 enables counter mode |
| iv_wr_en | input | 1 | Counter-block word write strobe |
| iv_wr_idx | input | 2 | Word index for the write |
| iv_wr_data | input | 32 | Write data |
| iv_rd_idx | input | 2 | Word index for readback |
| iv_rd_data | output | 32 | Registered readback word |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted when high with in_valid |
| in_data | input | 128 | Plaintext or ciphertext block |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 128 | Result block |
| eng_start | output | 1 | Engine request pulse |
| eng_block | output | 128 | Counter block sent to the engine |
| eng_done | input | 1 | Engine response pulse |
| eng_keystream | input | 128 | Engine output for the requested block |

## Verification
The bench builds the block with its default widths: a 128-bit block, 32-bit words and a 3-bit mode field. Under these widths the real carry boundary at 32'hFFFFFFFF can be reached by loading word 0 directly, without running billions of blocks. The stand-in engine answers after a latency that the bench sets. A long latency leaves room for word writes while a block is in flight, and a stalling consumer exercises the output hold.

// File: rtl/ctr_seq_pkg.sv
package ctr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OUT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec #(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] CTR_CODE = 3'b010
) (
  input  logic [MODE_W-1:0] mode,
  output logic              ctr_en
);
  always_comb ctr_en = (mode == CTR_CODE);
endmodule

// File: rtl/ctr_iv_bank.sv
module ctr_iv_bank #(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(BLK_W/WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              inc,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic [BLK_W-1:0]  blk
);
  localparam int N_WORDS = BLK_W / WORD_W;

  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    if (i == 0) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst)
          words[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))
          words[i] <= wr_data;
        else if (inc)
          words[i] <= words[i] + WORD_W'(1);
      end
    end else begin : g_nonce
      always_ff @(posedge clk) begin
        if (rst)
          words[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))
          words[i] <= wr_data;
      end
    end
    assign blk[i*WORD_W +: WORD_W] = words[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= words[rd_idx];
  end

  // R4: the nonce words move only through a write
  a_r4_nonce_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(blk[BLK_W-1:WORD_W]));

  // R5: the counter word steps by one modulo 2^WORD_W
  a_r5_wrap_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !wr_en) |=> (blk[WORD_W-1:0] == WORD_W'($past(blk[WORD_W-1:0]) + 1'b1)));
endmodule

// File: rtl/ctr_xor_out.sv
module ctr_xor_out #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] keystream,
  input  logic [BLK_W-1:0] data,
  input  logic             ready,
  output logic             valid,
  output logic [BLK_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      result <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      result <= keystream ^ data;
    end else if (valid && ready) begin
      valid  <= 1'b0;
    end
  end

  // R8: a pending output is held until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(result)));
endmodule

// File: rtl/ctr_keystream_seq.sv
module ctr_keystream_seq #(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32,
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] CTR_CODE = 3'b010,
  parameter int IDX_W  = $clog2(BLK_W/WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] chain_mode,
  input  logic              iv_wr_en,
  input  logic [IDX_W-1:0]  iv_wr_idx,
  input  logic [WORD_W-1:0] iv_wr_data,
  input  logic [IDX_W-1:0]  iv_rd_idx,
  output logic [WORD_W-1:0] iv_rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_data,
  output logic              eng_start,
  output logic [BLK_W-1:0]  eng_block,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_keystream
);
  import ctr_seq_pkg::*;

  seq_state_e       state_q;
  logic             ctr_en;
  logic             accept;
  logic             out_fire;
  logic             ks_load;
  logic             iv_wr_ok;
  logic             start_q;
  logic [BLK_W-1:0] blk_q;
  logic [BLK_W-1:0] din_q;
  logic [BLK_W-1:0] cnt_blk;

  ctr_mode_dec #(.MODE_W(MODE_W), .CTR_CODE(CTR_CODE)) u_dec (
    .mode   (chain_mode),
    .ctr_en (ctr_en)
  );

  assign in_ready = (state_q == ST_IDLE) && ctr_en;
  assign accept   = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign ks_load  = (state_q == ST_WAIT) && eng_done;
  assign iv_wr_ok = iv_wr_en && (state_q == ST_IDLE);

  ctr_iv_bank #(.BLK_W(BLK_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (iv_wr_ok),
    .wr_idx  (iv_wr_idx),
    .wr_data (iv_wr_data),
    .inc     (out_fire),
    .rd_idx  (iv_rd_idx),
    .rd_data (iv_rd_data),
    .blk     (cnt_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      blk_q   <= '0;
      din_q   <= '0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          din_q   <= in_data;
          blk_q   <= cnt_blk;
          start_q <= 1'b1;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (eng_done) state_q <= ST_OUT;
        ST_OUT:  if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign eng_start = start_q;
  assign eng_block = blk_q;

  ctr_xor_out #(.BLK_W(BLK_W)) u_xor (
    .clk       (clk),
    .rst       (rst),
    .load      (ks_load),
    .keystream (eng_keystream),
    .data      (din_q),
    .ready     (out_ready),
    .valid     (out_valid),
    .result    (out_data)
  );

  // R7: a request is a single-cycle pulse
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R1: a request follows an input handshake
  a_r1_start_after_accept: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(in_valid && in_ready));

  // R7: no new input while a result is pending
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid);

  // R6: writes while busy leave the counter block alone
  a_r6_busy_write: assert property (@(posedge clk) disable iff (rst)
    ((state_q != ST_IDLE) && !out_fire) |=> $stable(cnt_blk));
endmodule

// File: tb/sim_ctr_keystream_seq.sv
`timescale 1ns/1ps
module sim_ctr_keystream_seq;
  localparam int BW = 128;
  localparam int WW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]    chain_mode = 3'b000;
  logic          iv_wr_en = 1'b0;
  logic [1:0]    iv_wr_idx = '0;
  logic [WW-1:0] iv_wr_data = '0;
  logic [1:0]    iv_rd_idx = '0;
  logic [WW-1:0] iv_rd_data;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [BW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [BW-1:0] out_data;
  logic          eng_start;
  logic [BW-1:0] eng_block;
  logic          eng_done = 1'b0;
  logic [BW-1:0] eng_keystream = '0;

  always #2.5 clk = ~clk;

  ctr_keystream_seq u0 (.*);

  int total = 0;
  int bad = 0;
  logic [BW-1:0] exp_q[$];
  logic [BW-1:0] blk_q[$];
  logic [BW-1:0] got_log[$];
  logic [BW-1:0] model_blk;
  int eng_lat = 2;
  int eng_cnt = 0;
  logic [BW-1:0] eng_hold;
  int stall_pat = 0;
  int starts = 0;
  logic held_v = 1'b0;
  logic [BW-1:0] held_d;

  function automatic logic [BW-1:0] ks(input logic [BW-1:0] b);
    return {b[100:0], b[127:101]} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  endfunction

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stand-in cipher engine; also checks the presented block
  always @(negedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      starts++;
      if (blk_q.size() > 0) check("R2/R4 eng_block", eng_block, blk_q.pop_front());
      eng_hold = ks(eng_block);
      eng_cnt = eng_lat;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_done <= 1'b1;
        eng_keystream <= eng_hold;
      end
    end
  end

  // monitor with a stalling consumer
  always @(negedge clk) begin
    logic nr;
    stall_pat++;
    nr = (stall_pat % 3) != 0;
    if (held_v && out_valid) check("R8 hold", out_data, held_d);
    out_ready = nr;
    if (out_valid && nr) begin
      if (exp_q.size() > 0) check("R3 out_data", out_data, exp_q.pop_front());
      else check("R3 unexpected output", out_data, '0);
      got_log.push_back(out_data);
      held_v = 1'b0;
    end else begin
      held_v = out_valid;
      held_d = out_data;
    end
  end

  task automatic send(input logic [BW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(ks(model_blk) ^ d);
    blk_q.push_back(model_blk);
    model_blk[WW-1:0] = model_blk[WW-1:0] + 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0 || out_valid || eng_cnt > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [WW-1:0] d);
    @(negedge clk);
    iv_wr_en = 1'b1; iv_wr_idx = idx; iv_wr_data = d;
    @(negedge clk);
    iv_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [WW-1:0] d);
    @(negedge clk);
    iv_rd_idx = idx;
    @(negedge clk);
    d = iv_rd_data;
  endtask

  task automatic load_blk(input logic [BW-1:0] b);
    for (int i = 0; i < 4; i++) wr(2'(i), b[i*WW +: WW]);
    model_blk = b;
  endtask

  initial begin
    logic [WW-1:0] w;
    logic [BW-1:0] pt [4];
    int s0;
    model_blk = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {127'd0, out_valid}, '0);
    check("R10 eng_start", {127'd0, eng_start}, '0);
    rd(2'd0, w); check("R10 word0", {96'd0, w}, '0);
    rd(2'd3, w); check("R10 word3", {96'd0, w}, '0);

    // R1 wrong mode: no acceptance, no request
    s0 = starts;
    chain_mode = 3'b011;
    in_valid = 1'b1; in_data = 128'h1;
    repeat (6) begin
      @(negedge clk);
      check("R1 in_ready low", {127'd0, in_ready}, '0);
    end
    in_valid = 1'b0;
    check("R1 no engine start", 128'(starts), 128'(s0));
    chain_mode = 3'b010;
    @(negedge clk);
    check("R1 in_ready with 010", {127'd0, in_ready}, 128'd1);

    // R2 / R9 load and read back
    load_blk(128'hCAFEBABE_01234567_89ABCDEF_00000001);
    rd(2'd3, w); check("R2 R9 word3", {96'd0, w}, {96'd0, 32'hCAFEBABE});
    rd(2'd2, w); check("R2 R9 word2", {96'd0, w}, {96'd0, 32'h01234567});
    rd(2'd1, w); check("R2 R9 word1", {96'd0, w}, {96'd0, 32'h89ABCDEF});
    rd(2'd0, w); check("R2 R9 word0", {96'd0, w}, {96'd0, 32'h00000001});

    // R3 R4 R8 several patterns
    pt[0] = '0;
    pt[1] = '1;
    pt[2] = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    pt[3] = 128'h80000000_00000000_00000000_00000001;
    got_log.delete();
    for (int i = 0; i < 4; i++) send(pt[i]);
    drain();
    rd(2'd0, w); check("R4 counter after 4", {96'd0, w}, {96'd0, 32'd5});
    rd(2'd1, w); check("R4 nonce word1", {96'd0, w}, {96'd0, 32'h89ABCDEF});

    // R11 decryption: same counters, ciphertext in, plaintext out
    begin
      logic [BW-1:0] ct [4];
      for (int i = 0; i < 4; i++) ct[i] = got_log[i];
      load_blk(128'hCAFEBABE_01234567_89ABCDEF_00000001);
      got_log.delete();
      for (int i = 0; i < 4; i++) send(ct[i]);
      drain();
      for (int i = 0; i < 4; i++) check("R11 decrypt", got_log[i], pt[i]);
    end

    // R5 wrap
    load_blk(128'h11111111_22222222_33333333_FFFFFFFE);
    for (int i = 0; i < 3; i++) send(128'(i + 7));
    drain();
    rd(2'd0, w); check("R5 wrapped counter", {96'd0, w}, {96'd0, 32'd1});
    rd(2'd1, w); check("R5 nonce untouched", {96'd0, w}, {96'd0, 32'h33333333});

    // R6 write while busy is ignored
    eng_lat = 8;
    send(128'hABCD);
    wr(2'd0, 32'h5555_0000);
    wr(2'd2, 32'h7777_7777);
    drain();
    rd(2'd0, w); check("R6 word0 after busy write", {96'd0, w}, {96'd0, 32'd2});
    rd(2'd2, w); check("R6 word2 after busy write", {96'd0, w}, {96'd0, 32'h22222222});
    eng_lat = 2;

    // R7 one request per block
    s0 = starts;
    send(128'h1); send(128'h2);
    drain();
    check("R7 request count", 128'(starts - s0), 128'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule